// File: doc/BRIEF.md
# Static LCD Segment Driver

This block turns a latched three-and-a-half digit reading into the drive lines of a direct-drive liquid crystal panel. It receives three BCD digits, a leading-one flag for the half digit, and a minus flag. On a one-cycle new-reading strobe it captures them. It produces a backplane square wave and one line per segment. Those lines are the three full seven-segment digits, one shared line for the half digit's two right-hand bars, and a minus segment.

Each segment line copies the backplane when the segment is dark and its inverse when the segment is lit. A lit segment therefore sees a full swing with no net DC across the glass. The backplane is the input clock divided first by a prescaler and then by a second divider, which gives 800 clocks per period by default. A lamp-test input lights every segment so the panel reads as a full "1888" with the sign. While it is active it holds every segment line at a constant high level instead of alternating.

Top module: `lcd_static_drive`

## Requirements
- R1: The backplane is a 50% duty square wave. It toggles once every PRESCALE*BP_DIV/2 clocks, which is 400 by default. It is low in reset, and its first rise is on the 400th rising clock edge after reset is released.
- R2: A dark segment line equals the backplane level in every cycle.
- R3: A lit segment line equals the inverse of the backplane level. It changes on the same clock edge as the backplane toggle.
- R4: Each full digit maps segment a to bit 0 through segment g to bit 6. Codes 0..9 light the hex patterns 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F.
- R5: BCD codes 10 to 15 blank the digit, so all seven lines of that digit are dark.
- R6: The shared half-digit line is lit exactly when the captured leading-one flag is 1. The minus line is lit exactly when the captured minus flag is 1.
- R7: Digit, leading-one and minus inputs are captured only on an edge where loadStrobe is high. The segment lines show the new value from the following edge onward. Input changes without the strobe have no effect.
- R8: While lampTest is high, all 23 segment lines read 1 from the edge after it rises. They stay at 1 across backplane toggles, and the backplane keeps toggling. One edge after lampTest falls, normal drive resumes.
- R9: Reset clears the captured content to blank with no leading one and no minus. After release every segment line therefore follows the backplane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Active-low synchronous reset |
| digitOnes | input | 4 | BCD units digit |
| digitTens | input | 4 | BCD tens digit |
| digitHundreds | input | 4 | BCD hundreds digit |
| leadOne | input | 1 | Half digit shows "1" |
| negSign | input | 1 | Reading is negative |
| loadStrobe | input | 1 | New-reading capture strobe |
| lampTest | input | 1 | Force all segments on, constant level |
| backplane | output | 1 | Backplane square wave |
| segOnes | output | 7 | Units digit segments a..g (bit 0 = a) |
| segTens | output | 7 | Tens digit segments a..g |
| segHundreds | output | 7 | Hundreds digit segments a..g |
| segHalfBc | output | 1 | Shared b/c line of the half digit |
| segMinus | output | 1 | Minus segment |

## Verification
A divider that slips a count shows up at the next backplane toggle, within 400 clocks, as a misplaced edge that the bench's free-running edge count exposes. A wrong captured code or a decode error appears on the edge after the load as a segment line with the wrong phase against the backplane. A capture that leaks without a strobe changes a line within one cycle. Lamp-test faults show within one edge as a segment line that alternates or sits low while the override is held.

// File: rtl/lcd_drive_pkg.sv
package lcd_drive_pkg;

  typedef struct packed {
    logic flip;   // backplane toggles on this edge
    logic latch;  // capture a new reading on this edge
  } drvStrobe_t;

  // bit 0 = segment a ... bit 6 = segment g; codes above 9 are dark
  function automatic logic [6:0] decodeDigit(input logic [3:0] code);
    logic [6:0] pat;
    case (code)
      4'd0: pat = 7'h3F;
      4'd1: pat = 7'h06;
      4'd2: pat = 7'h5B;
      4'd3: pat = 7'h4F;
      4'd4: pat = 7'h66;
      4'd5: pat = 7'h6D;
      4'd6: pat = 7'h7D;
      4'd7: pat = 7'h07;
      4'd8: pat = 7'h7F;
      4'd9: pat = 7'h6F;
      default: pat = 7'h00;
    endcase
    return pat;
  endfunction

endpackage

// File: rtl/lcd_drive_ctrl.sv
module lcd_drive_ctrl
  import lcd_drive_pkg::*;
#(
  parameter int PRESCALE = 4,
  parameter int BP_DIV   = 200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       loadStrobe,
  output drvStrobe_t strobe
);
  localparam int HALF   = BP_DIV / 2;
  localparam int HALF_W = (HALF > 1) ? $clog2(HALF) : 1;

  logic tick;

  generate
    if (PRESCALE > 1) begin : g_pre
      localparam int PRE_W = $clog2(PRESCALE);
      logic [PRE_W-1:0] preCnt;
      always_ff @(posedge clk) begin
        if (!rstN)                             preCnt <= '0;
        else if (preCnt == PRE_W'(PRESCALE-1)) preCnt <= '0;
        else                                   preCnt <= preCnt + 1'b1;
      end
      assign tick = (preCnt == PRE_W'(PRESCALE-1));
    end else begin : g_nopre
      assign tick = 1'b1;
    end
  endgenerate

  logic [HALF_W-1:0] halfCnt;
  logic              halfEnd;

  assign halfEnd = (halfCnt == HALF_W'(HALF-1));

  always_ff @(posedge clk) begin
    if (!rstN)     halfCnt <= '0;
    else if (tick) halfCnt <= halfEnd ? '0 : halfCnt + 1'b1;
  end

  always_comb begin
    strobe.flip  = tick && halfEnd;
    strobe.latch = loadStrobe;
  end

endmodule

// File: rtl/lcd_drive_datapath.sv
module lcd_drive_datapath
  import lcd_drive_pkg::*;
#(
  parameter int DIGITS = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  drvStrobe_t             strobe,
  input  logic [DIGITS-1:0][3:0] digitsIn,
  input  logic                   leadOne,
  input  logic                   negSign,
  input  logic                   lampTest,
  output logic                   backplane,
  output logic [DIGITS-1:0][6:0] segDigits,
  output logic                   segHalfBc,
  output logic                   segMinus
);
  logic                   bpQ, bpNext;
  logic [DIGITS-1:0][3:0] codeQ;
  logic                   oneQ, minusQ;

  assign bpNext = strobe.flip ? ~bpQ : bpQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bpQ    <= 1'b0;
      codeQ  <= {DIGITS{4'hF}};
      oneQ   <= 1'b0;
      minusQ <= 1'b0;
    end else begin
      bpQ <= bpNext;
      if (strobe.latch) begin
        codeQ  <= digitsIn;
        oneQ   <= leadOne;
        minusQ <= negSign;
      end
    end
  end

  generate
    for (genvar i = 0; i < DIGITS; i++) begin : g_digit
      logic [6:0] litPat;
      logic [6:0] segQ;
      assign litPat = decodeDigit(codeQ[i]);
      always_ff @(posedge clk) begin
        if (!rstN)         segQ <= '0;
        else if (lampTest) segQ <= '1;
        else               segQ <= {7{bpNext}} ^ litPat;
      end
      assign segDigits[i] = segQ;
    end
  endgenerate

  logic halfQ, minusSegQ;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      halfQ     <= 1'b0;
      minusSegQ <= 1'b0;
    end else if (lampTest) begin
      halfQ     <= 1'b1;
      minusSegQ <= 1'b1;
    end else begin
      halfQ     <= bpNext ^ oneQ;
      minusSegQ <= bpNext ^ minusQ;
    end
  end

  assign backplane = bpQ;
  assign segHalfBc = halfQ;
  assign segMinus  = minusSegQ;

endmodule

// File: rtl/lcd_static_drive.sv
module lcd_static_drive
  import lcd_drive_pkg::*;
#(
  parameter int PRESCALE = 4,
  parameter int BP_DIV   = 200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] digitOnes,
  input  logic [3:0] digitTens,
  input  logic [3:0] digitHundreds,
  input  logic       leadOne,
  input  logic       negSign,
  input  logic       loadStrobe,
  input  logic       lampTest,
  output logic       backplane,
  output logic [6:0] segOnes,
  output logic [6:0] segTens,
  output logic [6:0] segHundreds,
  output logic       segHalfBc,
  output logic       segMinus
);
  localparam int DIGITS = 3;

  drvStrobe_t             strobe;
  logic [DIGITS-1:0][6:0] segDigits;

  lcd_drive_ctrl #(.PRESCALE(PRESCALE), .BP_DIV(BP_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .loadStrobe(loadStrobe), .strobe(strobe)
  );

  lcd_drive_datapath #(.DIGITS(DIGITS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .digitsIn({digitHundreds, digitTens, digitOnes}),
    .leadOne(leadOne), .negSign(negSign), .lampTest(lampTest),
    .backplane(backplane), .segDigits(segDigits),
    .segHalfBc(segHalfBc), .segMinus(segMinus)
  );

  assign segOnes     = segDigits[0];
  assign segTens     = segDigits[1];
  assign segHundreds = segDigits[2];

endmodule

// File: rtl/lcd_static_drive_chk.sv
module lcd_static_drive_chk #(
  parameter int HALF_CYC = 400
) (
  input logic       clk,
  input logic       rstN,
  input logic       loadStrobe,
  input logic       lampTest,
  input logic       backplane,
  input logic [6:0] segOnes,
  input logic [6:0] segTens,
  input logic [6:0] segHundreds,
  input logic       segHalfBc,
  input logic       segMinus
);
  logic [22:0] allSeg;
  assign allSeg = {segHundreds, segTens, segOnes, segHalfBc, segMinus};

  logic        armed, seenEdge, lastBp;
  logic [31:0] runLen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed    <= 1'b0;
      seenEdge <= 1'b0;
      lastBp   <= 1'b0;
      runLen   <= '0;
    end else begin
      armed  <= 1'b1;
      lastBp <= backplane;
      if (backplane != lastBp) begin
        seenEdge <= 1'b1;
        runLen   <= 32'd1;
      end else begin
        runLen <= runLen + 32'd1;
      end
    end
  end

  // R1: spacing between backplane toggles is a fixed half period
  a_r1_half_period: assert property (@(posedge clk) disable iff (!rstN)
    (seenEdge && backplane != lastBp) |-> (runLen == 32'(HALF_CYC)));

  // R3: every segment line flips on the same edge as the backplane
  a_r3_flip_with_bp: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !$past(lampTest) && !$past(lampTest, 2) && !$past(loadStrobe, 2)
     && backplane != $past(backplane)) |-> (allSeg == ~$past(allSeg)));

  // R7: with no capture and no override, lines hold between toggles
  a_r7_hold_steady: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !$past(lampTest) && !$past(lampTest, 2) && !$past(loadStrobe, 2)
     && backplane == $past(backplane)) |-> (allSeg == $past(allSeg)));

  // R8: lamp test forces every segment line high
  a_r8_lamp_all_on: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(lampTest)) |-> (allSeg == '1));

endmodule

bind lcd_static_drive lcd_static_drive_chk #(.HALF_CYC(PRESCALE*BP_DIV/2)) u_chk (
  .clk(clk), .rstN(rstN), .loadStrobe(loadStrobe), .lampTest(lampTest),
  .backplane(backplane), .segOnes(segOnes), .segTens(segTens),
  .segHundreds(segHundreds), .segHalfBc(segHalfBc), .segMinus(segMinus)
);

// File: tb/sim_lcd_static_drive.sv
`timescale 1ns/1ps
module sim_lcd_static_drive;
  localparam int HALF_CYC = 400;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] digitOnes = '0, digitTens = '0, digitHundreds = '0;
  logic leadOne = 1'b0, negSign = 1'b0, loadStrobe = 1'b0, lampTest = 1'b0;
  logic backplane, segHalfBc, segMinus;
  logic [6:0] segOnes, segTens, segHundreds;

  always #2 clk = ~clk;

  lcd_static_drive u0 (.*);

  int checks = 0, fails = 0;
  int edgeCnt = 0;
  bit done = 0;

  // captured-reading model
  logic [3:0] mOnes = 4'hF, mTens = 4'hF, mHund = 4'hF;
  logic       mOne = 1'b0, mMinus = 1'b0;

  always @(posedge clk) if (rstN) edgeCnt <= edgeCnt + 1;

  function automatic logic [6:0] pat(input logic [3:0] c);
    case (c)
      4'd0: return 7'h3F; 4'd1: return 7'h06; 4'd2: return 7'h5B;
      4'd3: return 7'h4F; 4'd4: return 7'h66; 4'd5: return 7'h6D;
      4'd6: return 7'h7D; 4'd7: return 7'h07; 4'd8: return 7'h7F;
      4'd9: return 7'h6F; default: return 7'h00;
    endcase
  endfunction

  function automatic logic expBp();
    return logic'((edgeCnt / HALF_CYC) % 2);
  endfunction

  task automatic checkAll(input string req, input bit lamp);
    logic        bp;
    logic [22:0] exp, act;
    bp  = expBp();
    exp = lamp ? '1 : ({23{bp}} ^ {pat(mHund), pat(mTens), pat(mOnes), mOne, mMinus});
    act = {segHundreds, segTens, segOnes, segHalfBc, segMinus};
    checks++;
    if (backplane !== bp) begin
      fails++;
      $display("FAIL %s backplane act=%b exp=%b edge=%0d", req, backplane, bp, edgeCnt);
    end
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s segments act=%h exp=%h edge=%0d", req, act, exp, edgeCnt);
    end
  endtask

  task automatic doLoad(input logic [3:0] h, t, o, input logic one, minus, input string req);
    @(negedge clk);
    digitHundreds = h; digitTens = t; digitOnes = o;
    leadOne = one; negSign = minus; loadStrobe = 1'b1;
    @(negedge clk);
    loadStrobe = 1'b0;
    checkAll({req, " R7 old value until next edge"}, 1'b0);
    mHund = h; mTens = t; mOnes = o; mOne = one; mMinus = minus;
    @(negedge clk);
    checkAll(req, 1'b0);
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired act=running exp=done");
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R9 reset blank", 1'b0);

    // R1: edges around the first toggle
    while (edgeCnt < HALF_CYC - 1) @(negedge clk);
    checkAll("R1 before first toggle", 1'b0);
    @(negedge clk);
    checkAll("R1 first toggle", 1'b0);
    while (edgeCnt < 2*HALF_CYC) @(negedge clk);
    checkAll("R1 second toggle", 1'b0);

    // R4: all decimal codes, R6 flags
    for (int d = 0; d < 10; d++) begin
      doLoad(4'(d), 4'((d+3)%10), 4'((d+7)%10), d[0], d[1], "R4 digit patterns");
      repeat (7) @(negedge clk);
      checkAll("R2 dark lines follow backplane", 1'b0);
    end

    // R5: blank codes
    doLoad(4'hA, 4'hC, 4'hF, 1'b0, 1'b0, "R5 codes above nine blank");
    doLoad(4'hB, 4'hD, 4'hE, 1'b1, 1'b1, "R6 flags with blank digits");

    // R3: lit lines straddle a backplane toggle
    doLoad(4'd8, 4'd8, 4'd8, 1'b1, 1'b1, "R3 all lit");
    while ((edgeCnt % HALF_CYC) != HALF_CYC - 1) @(negedge clk);
    checkAll("R3 just before toggle", 1'b0);
    @(negedge clk);
    checkAll("R3 on toggle edge", 1'b0);

    // R7: input changes without strobe are ignored
    @(negedge clk);
    digitHundreds = 4'd1; digitTens = 4'd2; digitOnes = 4'd3; leadOne = 0; negSign = 0;
    repeat (5) @(negedge clk);
    checkAll("R7 no strobe no change", 1'b0);

    // R8: lamp test across a toggle, then release
    @(negedge clk); lampTest = 1'b1;
    @(negedge clk);
    checkAll("R8 lamp on", 1'b1);
    while ((edgeCnt % HALF_CYC) != 0) begin
      @(negedge clk);
      if ((edgeCnt % HALF_CYC) == 0 || (edgeCnt % 97) == 0) checkAll("R8 lamp constant", 1'b1);
    end
    lampTest = 1'b0;
    @(negedge clk);
    checkAll("R8 lamp released", 1'b0);

    // random readings and dwell times
    for (int n = 0; n < 60; n++) begin
      logic [3:0] h, t, o;
      h = 4'($urandom_range(0, 15)); t = 4'($urandom_range(0, 15)); o = 4'($urandom_range(0, 15));
      doLoad(h, t, o, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R4 R6 random reading");
      repeat ($urandom_range(1, 300)) @(negedge clk);
      checkAll("R2 R3 random dwell", 1'b0);
      if ($urandom_range(0, 7) == 0) begin
        lampTest = 1'b1;
        repeat ($urandom_range(1, 20)) @(negedge clk);
        checkAll("R8 random lamp", 1'b1);
        lampTest = 1'b0;
        @(negedge clk);
        checkAll("R8 random release", 1'b0);
      end
    end

    done = 1;
    finishRun();
  end

endmodule